// File: doc/BRIEF.md
# Two-Requester Hardware Lock

This block lets two processors that share a memory region take turns writing to it. Each side raises its request line and waits. When the block answers with a grant, that side owns the region until it drops its request. The check that the lock is free and the act of taking it happen together, on one clock edge, inside a single register update. Two sides therefore can never both find the lock free and both take it.

When both sides ask in the same cycle while the lock is free, a preference bit picks the winner. The preference always points at the side that did not receive the most recent grant, so a side that keeps losing ties gets the next one. The busy output reports whether anyone holds the lock. Both the grants and busy come from registers.

Top module: `pair_mutex`

## Requirements
- R1: After reset, busy is 0, both grant bits are 0, and the tie preference points at requester 0.
- R2: When the lock is free and exactly one request bit is set at a clock edge, the grant bit of that side (bit 0 for requester 0, bit 1 for requester 1) and busy are 1 after that edge. When the lock is free and no request is set, busy stays 0.
- R3: When the lock is free and both request bits are set at an edge, only the preferred side is granted after that edge.
- R4: Every grant moves the tie preference to the other side. A tie that follows a grant to side k therefore goes to the side that is not k.
- R5: A grant stays asserted for as long as its owner keeps its request high, whatever the other side does.
- R6: When the owner drops its request, its grant and busy are both 0 after the next edge.
- R7: While the lock is held, any change on the non-owner's request line leaves both grant bits and busy unchanged.
- R8: At most one grant bit is 1 in any cycle, and busy equals the OR of the grant bits.
- R9: A request that is pending during a release is granted one edge after busy falls, which leaves one free cycle between owners.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 2 | Request from each side; bit k belongs to requester k |
| gntOut | output | 2 | Registered grant; bit k means requester k owns the lock |
| busyOut | output | 1 | Registered lock state; 1 while someone holds the lock |

## Verification
The assertions assume that an owner keeps its request high until it has finished its writes, and that reqIn is stable around the rising edge. They assume nothing about how often either side asks. The bench changes reqIn only on falling edges. It plays every four-cycle request pattern from reset, then a long pseudo-random request stream, so that ties, re-requests right after a release, and non-owner toggling all occur many times while stable inputs are kept.

// File: rtl/pair_mutex_pkg.sv
package pair_mutex_pkg;

  // Number of requesters sharing the lock, and the width of an index into them.
  localparam int unsigned NumReq = 2;
  localparam int unsigned IdxW   = $clog2(NumReq);

  typedef logic [IdxW-1:0]   reqIdx_t;
  typedef logic [NumReq-1:0] reqVec_t;

  // Strobes that the control sends to the lock state registers.
  typedef struct packed {
    logic    take;    // lock is free and somebody asks: claim it on this edge
    reqIdx_t winner;  // which requester the claim goes to
    logic    drop;    // the current owner has let go
  } lockStrobe_t;

endpackage

// File: rtl/pair_mutex_ctrl.sv
module pair_mutex_ctrl
  import pair_mutex_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  reqVec_t     reqIn,
  input  logic        held,
  input  reqIdx_t     owner,
  input  reqIdx_t     favour,
  output lockStrobe_t strobe
);

  logic    anyReq;
  logic    bothReq;
  reqIdx_t soleIdx;

  assign anyReq  = |reqIn;
  assign bothReq = &reqIn;

  // A lone requester is the highest set bit (only one is set when this is used).
  always_comb begin
    soleIdx = '0;
    for (int k = 0; k < NumReq; k++) begin
      if (reqIn[k]) soleIdx = reqIdx_t'(k);
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.take   = !held && anyReq;
    strobe.winner = bothReq ? favour : soleIdx;
    strobe.drop   = held && !reqIn[owner];
  end

  // The chosen side must actually be asking (R2, R3).
  p_winner_asks_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> reqIn[strobe.winner]);

  // Claim and release never coincide: one needs a free lock, the other a held one (R6).
  p_take_drop_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.take && strobe.drop));

endmodule

// File: rtl/pair_mutex_state.sv
module pair_mutex_state
  import pair_mutex_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  reqVec_t     reqIn,
  input  lockStrobe_t strobe,
  output logic        held,
  output reqIdx_t     owner,
  output reqIdx_t     favour,
  output reqVec_t     gntQ
);

  // Lock bit, owner and tie preference: all updated together in one step.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      held   <= 1'b0;
      owner  <= '0;
      favour <= '0;
    end else if (strobe.take) begin
      held   <= 1'b1;
      owner  <= strobe.winner;
      favour <= ~strobe.winner;
    end else if (strobe.drop) begin
      held   <= 1'b0;
    end
  end

  // One registered grant bit per requester.
  for (genvar g = 0; g < NumReq; g++) begin : g_gnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        gntQ[g] <= 1'b0;
      end else if (strobe.take) begin
        gntQ[g] <= (strobe.winner == reqIdx_t'(g));
      end else if (strobe.drop) begin
        gntQ[g] <= 1'b0;
      end
    end

    // An owner that keeps asking keeps its grant, and nothing else moves (R5, R7).
    p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (gntQ[g] && reqIn[g]) |=> gntQ[g]);
    p_other_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
      (gntQ[g] && reqIn[g]) |=> ($stable(gntQ) && held));

    // Dropping the request frees the lock on the next edge (R6).
    p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
      (gntQ[g] && !reqIn[g]) |=> (!held && gntQ == '0));
  end

  p_onehot_gnt_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntQ));
  p_busy_matches_r8: assert property (@(posedge clk) disable iff (!rstN)
    held == (|gntQ));

  p_tie_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!held && (&reqIn)) |=> (gntQ == (reqVec_t'(1) << $past(favour))));

  p_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(held) |-> (favour != owner));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!held && reqIn == '0) |=> !held);

  p_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(held) |-> (gntQ == '0));

endmodule

// File: rtl/pair_mutex.sv
module pair_mutex
  import pair_mutex_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumReq-1:0] reqIn,
  output logic [NumReq-1:0] gntOut,
  output logic              busyOut
);

  lockStrobe_t strobe;
  logic        held;
  reqIdx_t     owner;
  reqIdx_t     favour;
  reqVec_t     gntQ;

  pair_mutex_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .reqIn  (reqIn),
    .held   (held),
    .owner  (owner),
    .favour (favour),
    .strobe (strobe)
  );

  pair_mutex_state state_i (
    .clk    (clk),
    .rstN   (rstN),
    .reqIn  (reqIn),
    .strobe (strobe),
    .held   (held),
    .owner  (owner),
    .favour (favour),
    .gntQ   (gntQ)
  );

  assign gntOut  = gntQ;
  assign busyOut = held;

endmodule

// File: tb/pair_mutex_tb_top.sv
module pair_mutex_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] reqIn = 2'b00;
  logic [1:0] gntOut;
  logic       busyOut;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  bit          done   = 1'b0;

  // Reference state, derived from the requirements.
  logic       mHeld;
  logic       mOwner;
  logic       mFav;
  logic       mPrevDrop;
  logic [1:0] mPrevReq;

  always #5 clk = ~clk;

  pair_mutex dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqIn   (reqIn),
    .gntOut  (gntOut),
    .busyOut (busyOut)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {gnt,busy} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN  = 1'b0;
    reqIn = 2'b00;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mHeld = 1'b0; mOwner = 1'b0; mFav = 1'b0; mPrevDrop = 1'b0; mPrevReq = 2'b00;
    // R1: idle outputs straight after reset
    check("R1", {gntOut, busyOut}, 3'b000);
  endtask

  // Drive one request pattern for one cycle and compare with the model.
  task automatic step(input logic [1:0] r);
    string      tag;
    logic [1:0] expG;
    logic       dropNow;
    reqIn = r;
    if (!mHeld && mPrevDrop && (|r))       tag = "R9";
    else if (!mHeld && r == 2'b11)         tag = mFav ? "R4" : "R3";
    else if (!mHeld)                       tag = "R2";
    else if (!r[mOwner])                   tag = "R6";
    else if (r[!mOwner] != mPrevReq[!mOwner]) tag = "R7";
    else                                   tag = "R5";
    dropNow = 1'b0;
    if (!mHeld && (|r)) begin
      mOwner = (r == 2'b11) ? mFav : r[1];
      mFav   = !mOwner;
      mHeld  = 1'b1;
    end else if (mHeld && !r[mOwner]) begin
      mHeld   = 1'b0;
      dropNow = 1'b1;
    end
    mPrevDrop = dropNow;
    mPrevReq  = r;
    expG = mHeld ? (2'b01 << mOwner) : 2'b00;
    @(negedge clk);
    check(tag, {gntOut, busyOut}, {expG, mHeld});
    // R8: at most one grant, busy is their OR
    check("R8", {1'b0, ($countones(gntOut) <= 1), (busyOut == |gntOut)}, 3'b011);
  endtask

  initial begin
    logic [15:0] lfsr;
    doReset();

    // Directed: single claim, hold under contention, release, hand-over, tie.
    step(2'b01);   // R2 requester 0
    step(2'b11);   // R5 / R7 other side asks
    step(2'b01);   // R7 other side withdraws
    step(2'b10);   // R6 owner 0 drops while 1 waits
    step(2'b10);   // R9 waiting side granted after gap
    step(2'b11);   // R7
    step(2'b00);   // R6
    step(2'b11);   // R3 tie, preference back to 0
    step(2'b00);
    step(2'b11);   // R4 tie after grant to 0 goes to 1
    step(2'b00);

    // Exhaustive: every four-cycle request pattern from reset.
    for (int seq = 0; seq < 256; seq++) begin
      doReset();
      for (int c = 0; c < 4; c++) step(2'((seq >> (2 * c)) & 3));
    end

    // Long pseudo-random stream with a bias towards holding requests.
    doReset();
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step((lfsr[3:2] == 2'b00) ? lfsr[1:0] : reqIn);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule